// File: doc/BRIEF.md
# TLB Miss Refill Walker

This block services a translation miss without software help. When a miss arrives, it builds the address of the page-table entry that describes the missing page. The address is formed from a page-table base value and the virtual address. The block sends that address through the same TLB lookup port as an ordinary data read at the most privileged level. This translation cannot trigger a second refill. If the lookup faults, the walker reports that fault and stops.

If the lookup succeeds, the walker reads the 32-bit entry from memory over a request/response port. It then writes a new TLB entry into one of four refill ways. The way is picked by a rotating counter. The block also records the virtual address that missed, so the exception-address register can be loaded from it. Each accepted miss ends with exactly one single-cycle response that carries a fault flag and a cause code.

Top module: `tlb_refill_walker`

## Requirements
- R1: The entry address sent on the lookup port is (`pt_base` OR (`miss_vaddr` >> 10)) with bits 1:0 forced to zero. The lookup is issued with `lk_is_data` = 1 and `lk_priv` = 0.
- R2: When the lookup returns `lk_fault` = 1, the walker responds with `rsp_fault` = 1 and `rsp_cause` = `lk_cause`. It issues no memory request and no TLB write, and it leaves `exc_vaddr` unchanged.
- R3: The memory request address equals the `lk_paddr` returned by the lookup. `mem_req_valid` and `mem_req_addr` stay steady until `mem_req_ready` is seen.
- R4: The walker waits any number of cycles for the lookup response and for `mem_rsp_valid`.
- R5: A refill write carries the fetched word on `tw_pte` and its bits 5:4 on `tw_ring`. It carries the miss flag on `tw_is_data`. `tw_index` is `miss_vaddr[13:12]` and `tw_vpn` is `miss_vaddr[31:14]`.
- R6: A refill counter is cleared by reset and is incremented before use. Its low two bits give `tw_way`, so the refills after reset go to ways 1, 2, 3, 0, 1. Faulted walks do not advance the counter.
- R7: `exc_vaddr` reads zero after reset. It takes the missing virtual address on every successful refill, and at no other time.
- R8: After reset, `miss_ready` is 1, and `lk_valid`, `mem_req_valid`, `tw_en` and `rsp_valid` are 0.
- R9: A miss is taken only while `miss_ready` is 1. A `miss_valid` raised during a walk is ignored and starts no later walk.
- R10: A successful walk asserts `tw_en` for one cycle. `rsp_valid` follows in the next cycle with `rsp_fault` = 0. Each accepted miss produces exactly one response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pt_base | input | 32 | Page-table base value |
| miss_valid | input | 1 | Miss request |
| miss_ready | output | 1 | Walker idle; miss taken when both are high |
| miss_vaddr | input | 32 | Virtual address that missed |
| miss_is_data | input | 1 | 1 for a data miss, 0 for an instruction miss |
| lk_valid | output | 1 | Lookup request for the entry address |
| lk_vaddr | output | 32 | Entry address to translate |
| lk_is_data | output | 1 | Lookup side, always data |
| lk_priv | output | 2 | Lookup privilege, always 0 |
| lk_rsp_valid | input | 1 | Lookup result valid |
| lk_fault | input | 1 | Lookup failed |
| lk_cause | input | 6 | Fault cause from the lookup |
| lk_paddr | input | 32 | Translated entry address |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 32 | Physical read address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Page-table entry read back |
| tw_en | output | 1 | TLB write strobe |
| tw_is_data | output | 1 | Which TLB receives the write |
| tw_way | output | 2 | Victim refill way |
| tw_index | output | 2 | Entry index within the way |
| tw_vpn | output | 18 | Virtual page tag |
| tw_ring | output | 2 | Ring taken from the entry |
| tw_pte | output | 32 | Entry word written |
| rsp_valid | output | 1 | Walk finished |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_cause | output | 6 | Fault cause, zero on success |
| exc_vaddr | output | 32 | Recorded missing address |

## Verification
The case that is hardest to reach from the ports is the counter wrapping from way 3 back to way 0, with a faulted walk placed between refills. The fault must leave the rotation unchanged. The stimulus runs one ordered series of walks from reset and drops a lookup fault into the middle of the series, so the fourth successful refill has to land in way 0. A second hard case is a miss that arrives while the walker is busy. To produce it, the stimulus holds the lookup response back for several cycles and raises `miss_valid` during that window. It then watches the idle walker to confirm that no second walk begins.

// File: rtl/twk_pkg.sv
package twk_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_XLATE = 3'd1,
    S_READ  = 3'd2,
    S_WRITE = 3'd3,
    S_DONE  = 3'd4
  } walk_state_e;
endpackage

// File: rtl/twk_pte_addr.sv
// Page-table entry address: base OR (vaddr >> shift), low bits aligned.
module twk_pte_addr #(
  parameter int VA_W      = 32,
  parameter int PTE_SHIFT = 10,
  parameter int ALIGN_W   = 2
) (
  input  logic [VA_W-1:0] base,
  input  logic [VA_W-1:0] vaddr,
  output logic [VA_W-1:0] pte_addr
);
  localparam logic [VA_W-1:0] KEEP_MASK = ~((VA_W)'((1 << ALIGN_W) - 1));

  logic [VA_W-1:0] raw;

  always_comb begin
    raw      = base | (vaddr >> PTE_SHIFT);
    pte_addr = raw & KEEP_MASK;
  end
endmodule

// File: rtl/twk_victim_ctr.sv
// Refill counter: increment first, then use the low bits as the victim way.
module twk_victim_ctr #(
  parameter int CNT_W = 8,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             refill,
  output logic [WAY_W-1:0] way
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    way   = cnt_d[WAY_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (refill) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/twk_fsm.sv
module twk_fsm
  import twk_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PA_W       = 32,
  parameter int PTE_W      = 32,
  parameter int CAUSE_W    = 6,
  parameter int PAGE_SHIFT = 12,
  parameter int IDX_W      = 2,
  parameter int RING_LSB   = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              miss_valid,
  input  logic [VA_W-1:0]                   miss_vaddr,
  input  logic                              miss_is_data,
  input  logic [VA_W-1:0]                   pte_addr,
  output logic                              miss_ready,
  output logic                              lk_valid,
  output logic [VA_W-1:0]                   lk_vaddr,
  input  logic                              lk_rsp_valid,
  input  logic                              lk_fault,
  input  logic [CAUSE_W-1:0]                lk_cause,
  input  logic [PA_W-1:0]                   lk_paddr,
  output logic                              mem_req_valid,
  input  logic                              mem_req_ready,
  output logic [PA_W-1:0]                   mem_req_addr,
  input  logic                              mem_rsp_valid,
  input  logic [PTE_W-1:0]                  mem_rsp_data,
  output logic                              tw_en,
  output logic                              tw_is_data,
  output logic [IDX_W-1:0]                  tw_index,
  output logic [VA_W-PAGE_SHIFT-IDX_W-1:0]  tw_vpn,
  output logic [1:0]                        tw_ring,
  output logic [PTE_W-1:0]                  tw_pte,
  output logic                              rsp_valid,
  output logic                              rsp_fault,
  output logic [CAUSE_W-1:0]                rsp_cause,
  output logic [VA_W-1:0]                   exc_vaddr
);
  localparam int VPN_W = VA_W - PAGE_SHIFT - IDX_W;

  walk_state_e          state_q, state_d;
  logic [VA_W-1:0]      vaddr_q;
  logic                 is_data_q;
  logic [VA_W-1:0]      ptea_q;
  logic [PA_W-1:0]      paddr_q;
  logic [PTE_W-1:0]     pte_q;
  logic                 fault_q;
  logic [CAUSE_W-1:0]   cause_q;
  logic                 req_done_q, req_done_d;
  logic [VA_W-1:0]      exc_q;

  logic cap_miss, cap_lk, cap_pte, req_fire, upd_exc;

  // Next-state and enables
  always_comb begin
    cap_miss   = (state_q == S_IDLE) && miss_valid;
    cap_lk     = (state_q == S_XLATE) && lk_rsp_valid;
    req_fire   = (state_q == S_READ) && !req_done_q && mem_req_ready;
    cap_pte    = (state_q == S_READ) && req_done_q && mem_rsp_valid;
    upd_exc    = (state_q == S_WRITE);
    req_done_d = req_done_q;
    if (req_fire) req_done_d = 1'b1;
    if (cap_pte)  req_done_d = 1'b0;

    state_d = state_q;
    case (state_q)
      S_IDLE:  if (miss_valid)    state_d = S_XLATE;
      S_XLATE: if (lk_rsp_valid)  state_d = lk_fault ? S_DONE : S_READ;
      S_READ:  if (cap_pte)       state_d = S_WRITE;
      S_WRITE:                    state_d = S_DONE;
      S_DONE:                     state_d = S_IDLE;
      default:                    state_d = S_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      req_done_q <= 1'b0;
      vaddr_q    <= '0;
      is_data_q  <= 1'b0;
      ptea_q     <= '0;
      paddr_q    <= '0;
      pte_q      <= '0;
      fault_q    <= 1'b0;
      cause_q    <= '0;
      exc_q      <= '0;
    end else begin
      state_q    <= state_d;
      req_done_q <= req_done_d;
      if (cap_miss) begin
        vaddr_q   <= miss_vaddr;
        is_data_q <= miss_is_data;
        ptea_q    <= pte_addr;
      end
      if (cap_lk) begin
        paddr_q <= lk_paddr;
        fault_q <= lk_fault;
        cause_q <= lk_fault ? lk_cause : '0;
      end
      if (cap_pte) begin
        pte_q <= mem_rsp_data;
      end
      if (upd_exc) begin
        exc_q <= vaddr_q;
      end
    end
  end

  // Outputs
  always_comb begin
    miss_ready    = (state_q == S_IDLE);
    lk_valid      = (state_q == S_XLATE);
    lk_vaddr      = ptea_q;
    mem_req_valid = (state_q == S_READ) && !req_done_q;
    mem_req_addr  = paddr_q;
    tw_en         = (state_q == S_WRITE);
    tw_is_data    = is_data_q;
    tw_index      = vaddr_q[PAGE_SHIFT +: IDX_W];
    tw_vpn        = vaddr_q[VA_W-1 -: VPN_W];
    tw_ring       = pte_q[RING_LSB +: 2];
    tw_pte        = pte_q;
    rsp_valid     = (state_q == S_DONE);
    rsp_fault     = fault_q;
    rsp_cause     = cause_q;
    exc_vaddr     = exc_q;
  end
endmodule

// File: rtl/tlb_refill_walker.sv
module tlb_refill_walker #(
  parameter int VA_W       = 32,
  parameter int PA_W       = 32,
  parameter int PTE_W      = 32,
  parameter int CAUSE_W    = 6,
  parameter int PRIV_W     = 2,
  parameter int PAGE_SHIFT = 12,
  parameter int IDX_W      = 2,
  parameter int PTE_SHIFT  = 10,
  parameter int N_RWAYS    = 4,
  parameter int CNT_W      = 8,
  parameter int RING_LSB   = 4,
  localparam int WAY_W     = $clog2(N_RWAYS),
  localparam int VPN_W     = VA_W - PAGE_SHIFT - IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [VA_W-1:0]    pt_base,
  input  logic               miss_valid,
  output logic               miss_ready,
  input  logic [VA_W-1:0]    miss_vaddr,
  input  logic               miss_is_data,
  output logic               lk_valid,
  output logic [VA_W-1:0]    lk_vaddr,
  output logic               lk_is_data,
  output logic [PRIV_W-1:0]  lk_priv,
  input  logic               lk_rsp_valid,
  input  logic               lk_fault,
  input  logic [CAUSE_W-1:0] lk_cause,
  input  logic [PA_W-1:0]    lk_paddr,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [PA_W-1:0]    mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [PTE_W-1:0]   mem_rsp_data,
  output logic               tw_en,
  output logic               tw_is_data,
  output logic [WAY_W-1:0]   tw_way,
  output logic [IDX_W-1:0]   tw_index,
  output logic [VPN_W-1:0]   tw_vpn,
  output logic [1:0]         tw_ring,
  output logic [PTE_W-1:0]   tw_pte,
  output logic               rsp_valid,
  output logic               rsp_fault,
  output logic [CAUSE_W-1:0] rsp_cause,
  output logic [VA_W-1:0]    exc_vaddr
);
  // Asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  logic [VA_W-1:0] pte_addr;

  // The entry fetch is always a privileged data read
  assign lk_is_data = 1'b1;
  assign lk_priv    = '0;

  twk_pte_addr #(
    .VA_W      (VA_W),
    .PTE_SHIFT (PTE_SHIFT),
    .ALIGN_W   (2)
  ) u_addr (
    .base     (pt_base),
    .vaddr    (miss_vaddr),
    .pte_addr (pte_addr)
  );

  twk_victim_ctr #(
    .CNT_W (CNT_W),
    .WAY_W (WAY_W)
  ) u_victim (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .refill (tw_en),
    .way    (tw_way)
  );

  twk_fsm #(
    .VA_W       (VA_W),
    .PA_W       (PA_W),
    .PTE_W      (PTE_W),
    .CAUSE_W    (CAUSE_W),
    .PAGE_SHIFT (PAGE_SHIFT),
    .IDX_W      (IDX_W),
    .RING_LSB   (RING_LSB)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n_int),
    .miss_valid    (miss_valid),
    .miss_vaddr    (miss_vaddr),
    .miss_is_data  (miss_is_data),
    .pte_addr      (pte_addr),
    .miss_ready    (miss_ready),
    .lk_valid      (lk_valid),
    .lk_vaddr      (lk_vaddr),
    .lk_rsp_valid  (lk_rsp_valid),
    .lk_fault      (lk_fault),
    .lk_cause      (lk_cause),
    .lk_paddr      (lk_paddr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .tw_en         (tw_en),
    .tw_is_data    (tw_is_data),
    .tw_index      (tw_index),
    .tw_vpn        (tw_vpn),
    .tw_ring       (tw_ring),
    .tw_pte        (tw_pte),
    .rsp_valid     (rsp_valid),
    .rsp_fault     (rsp_fault),
    .rsp_cause     (rsp_cause),
    .exc_vaddr     (exc_vaddr)
  );
endmodule

// File: rtl/tlb_refill_walker_chk.sv
module tlb_refill_walker_chk #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int PTE_W = 32,
  parameter int WAY_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             miss_ready,
  input logic             lk_valid,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [PA_W-1:0]  mem_req_addr,
  input logic             tw_en,
  input logic [WAY_W-1:0] tw_way,
  input logic [1:0]       tw_ring,
  input logic [PTE_W-1:0] tw_pte,
  input logic             rsp_valid,
  input logic             rsp_fault,
  input logic [VA_W-1:0]  exc_vaddr
);
  logic [WAY_W-1:0] last_way;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     last_way <= '0;
    else if (tw_en) last_way <= tw_way;
  end

  // R3
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R6
  way_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tw_en |-> (tw_way == WAY_W'(last_way + 1'b1)));

  // R10
  rsp_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tw_en |=> (rsp_valid && !rsp_fault));

  // R2
  fault_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> !$past(tw_en));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_ready |-> (!lk_valid && !mem_req_valid && !tw_en && !rsp_valid));

  // R5
  ring_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tw_en |-> (tw_ring == tw_pte[5:4]));

  // R7
  exc_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(exc_vaddr) |-> $past(tw_en));
endmodule

bind tlb_refill_walker tlb_refill_walker_chk #(
  .VA_W  (VA_W),
  .PA_W  (PA_W),
  .PTE_W (PTE_W),
  .WAY_W (WAY_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .miss_ready    (miss_ready),
  .lk_valid      (lk_valid),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .tw_en         (tw_en),
  .tw_way        (tw_way),
  .tw_ring       (tw_ring),
  .tw_pte        (tw_pte),
  .rsp_valid     (rsp_valid),
  .rsp_fault     (rsp_fault),
  .exc_vaddr     (exc_vaddr)
);

// File: tb/tlb_refill_walker_tb.sv
module tlb_refill_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pt_base = 32'h8000_0000;
  logic        miss_valid = 1'b0;
  logic        miss_ready;
  logic [31:0] miss_vaddr = '0;
  logic        miss_is_data = 1'b0;
  logic        lk_valid;
  logic [31:0] lk_vaddr;
  logic        lk_is_data;
  logic [1:0]  lk_priv;
  logic        lk_rsp_valid = 1'b0;
  logic        lk_fault = 1'b0;
  logic [5:0]  lk_cause = '0;
  logic [31:0] lk_paddr = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        tw_en, tw_is_data;
  logic [1:0]  tw_way, tw_index, tw_ring;
  logic [17:0] tw_vpn;
  logic [31:0] tw_pte;
  logic        rsp_valid, rsp_fault;
  logic [5:0]  rsp_cause;
  logic [31:0] exc_vaddr;

  always #10 clk = ~clk;

  tlb_refill_walker u_dut (.*);

  typedef struct packed {
    logic [31:0] vaddr;
    logic [31:0] pteaddr;
    logic [31:0] paddr;
    logic [31:0] pte;
    logic [31:0] exc;
    logic        is_data;
    logic        fault;
    logic [5:0]  cause;
    logic [1:0]  way;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0, resp_count = 0, cyc = 0;
  int lk_delay = 0, rdy_delay = 0, rsp_delay = 0;
  int lk_wait = 0, rdy_wait = 0, rsp_wait = 0;
  logic rsp_pend = 1'b0, seen_tw = 1'b0;
  logic nxt_fault = 1'b0;
  logic [5:0] nxt_cause = '0;
  logic [31:0] nxt_pte = '0;
  logic [1:0] exp_cnt = '0;
  logic [31:0] exp_exc = '0;

  function automatic logic [31:0] xl(input logic [31:0] a);
    return a ^ 32'h4000_0000;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // TLB lookup model
  always @(negedge clk) begin
    lk_rsp_valid <= 1'b0;
    if (lk_valid && !lk_rsp_valid) begin
      if (lk_wait == lk_delay) begin
        lk_rsp_valid <= 1'b1;
        lk_paddr     <= xl(lk_vaddr);
        lk_fault     <= nxt_fault;
        lk_cause     <= nxt_cause;
        lk_wait      <= 0;
        chk("R1 entry address", 64'(lk_vaddr), 64'(q[0].pteaddr));
        chk("R1 lookup side/priv", 64'({lk_is_data, lk_priv}), 64'(3'b100));
      end else lk_wait <= lk_wait + 1;
    end
  end

  // Memory model
  always @(negedge clk) begin
    mem_req_ready <= 1'b0;
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && !mem_req_ready) begin
      if (rdy_wait == rdy_delay) begin
        mem_req_ready <= 1'b1;
        rdy_wait      <= 0;
        rsp_pend      <= 1'b1;
        rsp_wait      <= 0;
        chk("R3 memory address", 64'(mem_req_addr), 64'(q[0].paddr));
      end else rdy_wait <= rdy_wait + 1;
    end
    if (rsp_pend) begin
      if (rsp_wait == rsp_delay) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= nxt_pte;
        rsp_pend      <= 1'b0;
      end else rsp_wait <= rsp_wait + 1;
    end
  end

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && tw_en) begin
      seen_tw = 1'b1;
      chk("R6 victim way", 64'(tw_way), 64'(q[0].way));
      chk("R5 index", 64'(tw_index), 64'(q[0].vaddr[13:12]));
      chk("R5 vpn", 64'(tw_vpn), 64'(q[0].vaddr[31:14]));
      chk("R5 pte", 64'(tw_pte), 64'(q[0].pte));
      chk("R5 ring", 64'(tw_ring), 64'(q[0].pte[5:4]));
      chk("R5 side", 64'(tw_is_data), 64'(q[0].is_data));
    end
    if (rst_n && rsp_valid) begin
      chk("R10 response fault flag", 64'(rsp_fault), 64'(q[0].fault));
      chk("R2 response cause", 64'(rsp_cause), 64'(q[0].cause));
      chk("R2 write only on success", 64'(seen_tw), 64'(!q[0].fault));
      chk("R7 exception address", 64'(exc_vaddr), 64'(q[0].exc));
      void'(q.pop_front());
      seen_tw = 1'b0;
      resp_count++;
    end
  end

  task automatic do_miss(input logic [31:0] va, input logic isd, input logic [31:0] pte,
                         input logic flt, input logic [5:0] cs, input int ld,
                         input int rd, input int md, input logic intrude);
    exp_t e;
    int tgt;
    nxt_fault = flt; nxt_cause = cs; nxt_pte = pte;
    lk_delay = ld; rdy_delay = rd; rsp_delay = md;
    e.vaddr   = va;
    e.pteaddr = (pt_base | (va >> 10)) & ~32'h3;
    e.paddr   = xl(e.pteaddr);
    e.pte     = pte;
    e.is_data = isd;
    e.fault   = flt;
    e.cause   = flt ? cs : 6'h0;
    if (!flt) begin
      exp_cnt = exp_cnt + 2'd1;
      exp_exc = va;
    end
    e.way = exp_cnt;
    e.exc = exp_exc;
    q.push_back(e);
    tgt = resp_count + 1;
    @(negedge clk);
    while (!miss_ready) @(negedge clk);
    miss_valid = 1'b1; miss_vaddr = va; miss_is_data = isd;
    @(negedge clk);
    miss_valid = 1'b0;
    if (intrude) begin
      chk("R9 busy after accept", 64'(miss_ready), 64'(0));
      miss_valid = 1'b1; miss_vaddr = va ^ 32'hFFFF_0000; miss_is_data = ~isd;
      repeat (2) @(negedge clk);
      miss_valid = 1'b0;
    end
    while (resp_count < tgt) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      $display("FAIL R10 watchdog: actual=%0d expected<50000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R8 reset state
    chk("R8 miss_ready", 64'(miss_ready), 64'(1));
    chk("R8 outputs quiet", 64'({lk_valid, mem_req_valid, tw_en, rsp_valid}), 64'(0));
    chk("R8 exc_vaddr", 64'(exc_vaddr), 64'(0));

    // R1 R5 R6: data miss, no waits -> way 1
    do_miss(32'h1234_5678, 1'b1, 32'h000A_B035, 1'b0, 6'h0, 0, 0, 0, 1'b0);
    // R4: instruction miss with long waits -> way 2
    do_miss(32'hC001_F00C, 1'b0, 32'h5555_5017, 1'b0, 6'h0, 2, 3, 5, 1'b0);
    // R2: lookup fault, counter and exc_vaddr unchanged
    do_miss(32'h0000_4000, 1'b1, 32'hDEAD_BEEF, 1'b1, 6'h18, 1, 0, 0, 1'b0);
    // New base -> way 3
    pt_base = 32'h0040_0000;
    do_miss(32'hFFFF_FFFC, 1'b1, 32'h0000_0020, 1'b0, 6'h0, 0, 1, 0, 1'b0);
    // R6 wrap to way 0; R9 busy miss ignored
    do_miss(32'h0765_4321, 1'b0, 32'h0000_0001, 1'b0, 6'h0, 4, 0, 1, 1'b1);
    repeat (6) begin
      @(negedge clk);
      chk("R9 no walk from ignored miss", 64'({lk_valid, rsp_valid}), 64'(0));
    end
    // R4 R6: long memory waits -> way 1
    do_miss(32'h89AB_CDEF, 1'b1, 32'hFFFF_FF10, 1'b0, 6'h0, 6, 20, 20, 1'b0);
    chk("R10 one response per miss", 64'(resp_count), 64'(6));
    chk("R7 final exc_vaddr", 64'(exc_vaddr), 64'(32'h89AB_CDEF));
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule